// File: doc/BRIEF.md
# Time-Counter Event Interrupt Unit

This unit produces the interrupts of a real-time clock from its eight time fields: seconds, minutes, hours, day of month, day of week, day of year, month and year. It keeps no time of its own. The counter block that sits beside it supplies the current field values and one increment strobe per field. A register file supplies the alarm compare values, the enable bits, the mask bits and the write-one-to-clear strokes.

There are two event sources. The **tick source** fires when any field whose enable bit is set increments. The **alarm source** fires when every unmasked alarm field equals its counter field. It fires only on the cycle in which that combined comparison turns from false to true. Each source sets a sticky flag in a two-bit event-location word. A single interrupt line is asserted while either flag is set.

Top module: `rtc_event_irq`

## Requirements
- R1: While reset is asserted and on the first sampled cycle after it is released, `tick_flag`, `alarm_flag` and `irq` are all 0.
- R2: Enable and mask bit i both belong to field i, and field i occupies bits [i*CNT_W +: CNT_W] of the value vectors. The field order from 0 to 7 is seconds, minutes, hours, day of month, day of week, day of year, month, year. A strobe on field i while `tick_en[i]` is 1 sets `tick_flag` at the next clock edge.
- R3: A strobe on a field whose enable bit is 0 leaves `tick_flag` unchanged. All enable bits are expected to be 0 after reset.
- R4: Once set, `tick_flag` stays 1 until a location write (`loc_wr` = 1) with `loc_wdata[0]` = 1.
- R5: The alarm condition holds only when every field with mask bit 0 has an alarm value equal to its counter value. Fields with mask bit 1 are ignored.
- R6: `alarm_flag` is set only at the edge that follows a cycle where the alarm condition holds and did not hold in the cycle before. A condition that persists does not set it again after it has been cleared.
- R7: A location write with `loc_wdata[1]` = 1 clears `alarm_flag`. A data bit of 0 leaves the corresponding flag unchanged, so each flag clears independently.
- R8: With all eight mask bits set, `alarm_flag` is never set.
- R9: If a set condition and a clear of the same flag occur in the same cycle, the flag ends up set.
- R10: `irq` is 1 exactly when at least one of the two flags is 1.
- R11: The previous-match state resets to "no match". An alarm condition that already holds when reset is released therefore sets `alarm_flag` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_val | input | NUM_FIELDS*CNT_W | Current counter values, field i at [i*CNT_W +: CNT_W] |
| cnt_inc | input | NUM_FIELDS | Per-field increment strobes |
| alarm_val | input | NUM_FIELDS*CNT_W | Alarm compare values, same packing as cnt_val |
| tick_en | input | NUM_FIELDS | Per-field tick interrupt enables |
| alarm_mask | input | NUM_FIELDS | Per-field alarm masks (1 = ignore field) |
| loc_wr | input | 1 | Event-location write strobe |
| loc_wdata | input | 2 | Write-one-to-clear data: bit 0 tick, bit 1 alarm |
| tick_flag | output | 1 | Sticky tick event flag |
| alarm_flag | output | 1 | Sticky alarm event flag |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the unit with CNT_W = 2 and keeps the eight fields. With two-bit fields, each mismatched field can take a distinct nonzero difference cheaply. This narrow width makes it practical to sweep all 256 mask words against a set of single-field and multi-field mismatch patterns. Every pair of the 256 enable words and the eight single-field strobes is also swept. Each trial starts from a forced mismatch, so the alarm edge detection is exercised on every comparison. Directed sequences cover set-versus-clear collisions, clears with zero data bits, a persistent match, and a match that already holds when reset is released.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned LOC_W      = 2;
  localparam int unsigned LOC_TICK   = 0;
  localparam int unsigned LOC_ALARM  = 1;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned NF    = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NF*CNT_W-1:0] cnt_i,
  input  logic [NF*CNT_W-1:0] alm_i,
  input  logic [NF-1:0]       mask_i,
  output logic                match_o
);
  logic [NF-1:0] field_ok;

  for (genvar gi = 0; gi < NF; gi++) begin : g_field
    assign field_ok[gi] = mask_i[gi] |
                          (cnt_i[gi*CNT_W +: CNT_W] == alm_i[gi*CNT_W +: CNT_W]);
  end

  assign match_o = (&field_ok) & ~(&mask_i);

  // R8
  full_mask_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_i) |-> !match_o);
endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  // R7
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq #(
  parameter int unsigned NUM_FIELDS  = rtc_irq_pkg::NUM_FIELDS,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        arst_n,
  input  logic [NUM_FIELDS*CNT_W-1:0] cnt_val,
  input  logic [NUM_FIELDS-1:0]       cnt_inc,
  input  logic [NUM_FIELDS*CNT_W-1:0] alarm_val,
  input  logic [NUM_FIELDS-1:0]       tick_en,
  input  logic [NUM_FIELDS-1:0]       alarm_mask,
  input  logic                        loc_wr,
  input  logic [rtc_irq_pkg::LOC_W-1:0] loc_wdata,
  output logic                        tick_flag,
  output logic                        alarm_flag,
  output logic                        irq
);
  import rtc_irq_pkg::*;

  logic rst_n;
  logic match_now;
  logic prev_match_q;
  logic prev_match_d;
  logic tick_hit;
  logic alarm_edge;
  logic clr_tick;
  logic clr_alarm;

  rtc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n_o(rst_n)
  );

  rtc_alarm_cmp #(.NF(NUM_FIELDS), .CNT_W(CNT_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt_val),
    .alm_i  (alarm_val),
    .mask_i (alarm_mask),
    .match_o(match_now)
  );

  always_comb begin
    tick_hit     = |(cnt_inc & tick_en);
    alarm_edge   = match_now & ~prev_match_q;
    prev_match_d = match_now;
    clr_tick     = loc_wr & loc_wdata[LOC_TICK];
    clr_alarm    = loc_wr & loc_wdata[LOC_ALARM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_match_q <= 1'b0;
    else        prev_match_q <= prev_match_d;
  end

  rtc_irq_flag u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (tick_hit),
    .clr_i (clr_tick),
    .flag_o(tick_flag)
  );

  rtc_irq_flag u_alarm (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (alarm_edge),
    .clr_i (clr_alarm),
    .flag_o(alarm_flag)
  );

  assign irq = tick_flag | alarm_flag;

  // R2 R3
  tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_flag) |-> $past(|(cnt_inc & tick_en)));
  // R6
  alarm_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> ($past(match_now) && !$past(prev_match_q)));
  // R8
  alarm_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> !$past(&alarm_mask));
  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_flag && !alarm_flag) |-> !irq);
endmodule

// File: tb/sim_rtc_event_irq.sv
module sim_rtc_event_irq;
  localparam int NF = 8;
  localparam int W  = 2;

  logic          clk;
  logic          arst_n;
  logic [NF*W-1:0] cnt_val;
  logic [NF-1:0]   cnt_inc;
  logic [NF*W-1:0] alarm_val;
  logic [NF-1:0]   tick_en;
  logic [NF-1:0]   alarm_mask;
  logic          loc_wr;
  logic [1:0]    loc_wdata;
  logic          tick_flag;
  logic          alarm_flag;
  logic          irq;

  int checks;
  int failures;
  bit done;

  rtc_event_irq #(.NUM_FIELDS(NF), .CNT_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .arst_n(arst_n), .cnt_val(cnt_val), .cnt_inc(cnt_inc),
    .alarm_val(alarm_val), .tick_en(tick_en), .alarm_mask(alarm_mask),
    .loc_wr(loc_wr), .loc_wdata(loc_wdata), .tick_flag(tick_flag),
    .alarm_flag(alarm_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_irq();
    chk(irq == (tick_flag | alarm_flag), "R10 irq", int'(irq), int'(tick_flag | alarm_flag));
  endtask

  function automatic logic [NF*W-1:0] base_cnt();
    logic [NF*W-1:0] v;
    for (int i = 0; i < NF; i++) v[i*W +: W] = W'((i * 3 + 1) % 4);
    return v;
  endfunction

  function automatic logic [NF*W-1:0] skew(input logic [NF*W-1:0] v, input logic [NF-1:0] d);
    logic [NF*W-1:0] r;
    r = v;
    for (int i = 0; i < NF; i++)
      if (d[i]) r[i*W +: W] = v[i*W +: W] ^ W'((i % 3) + 1);
    return r;
  endfunction

  task automatic force_mismatch_and_clear();
    alarm_mask = '0;
    alarm_val  = skew(cnt_val, 8'hFF);
    cnt_inc    = '0;
    loc_wr     = 1'b1;
    loc_wdata  = 2'b11;
    step();
    loc_wr     = 1'b0;
    loc_wdata  = 2'b00;
  endtask

  initial begin
    done = 0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] diffs [10];
    checks = 0;
    failures = 0;
    arst_n = 1'b0;
    cnt_val = base_cnt();
    cnt_inc = '0;
    tick_en = '0;
    loc_wr = 1'b0;
    loc_wdata = 2'b00;
    // R11: condition already true while in reset
    alarm_mask = '0;
    alarm_val = cnt_val;
    repeat (3) step();
    // R1
    chk(!tick_flag && !alarm_flag && !irq, "R1 flags in reset",
        int'({tick_flag, alarm_flag, irq}), 0);
    arst_n = 1'b1;
    @(negedge clk);
    chk(!tick_flag && !alarm_flag && !irq, "R1 flags after release",
        int'({tick_flag, alarm_flag, irq}), 0);
    repeat (4) step();
    // R11
    chk(alarm_flag == 1'b1, "R11 match at reset release fires", int'(alarm_flag), 1);
    chk_irq();
    loc_wr = 1'b1; loc_wdata = 2'b10;
    step();
    loc_wr = 1'b0; loc_wdata = 2'b00;
    repeat (3) step();
    // R6
    chk(alarm_flag == 1'b0, "R6 persistent match no refire", int'(alarm_flag), 0);

    // R2 R3: every enable word against every single-field strobe
    for (int en = 0; en < 256; en++) begin
      for (int f = 0; f < NF; f++) begin
        force_mismatch_and_clear();
        tick_en = 8'(en);
        cnt_inc = 8'(1 << f);
        step();
        cnt_inc = '0;
        chk(tick_flag == en[f], en[f] ? "R2 enabled strobe" : "R3 disabled strobe",
            int'(tick_flag), int'(en[f]));
        chk_irq();
      end
    end

    // R5 R8 R6: all masks against mismatch patterns
    diffs[0] = 8'h00;
    for (int k = 0; k < 8; k++) diffs[k + 1] = 8'(1 << k);
    diffs[9] = 8'h5A;
    tick_en = '0;
    for (int m = 0; m < 256; m++) begin
      for (int d = 0; d < 10; d++) begin
        bit exp_m;
        force_mismatch_and_clear();
        alarm_mask = 8'(m);
        alarm_val = skew(cnt_val, diffs[d]);
        step();
        exp_m = (m != 255) && ((diffs[d] & ~8'(m)) == 8'h00);
        chk(alarm_flag == exp_m, (m == 255) ? "R8 all masked" : "R5 masked compare",
            int'(alarm_flag), int'(exp_m));
        chk_irq();
      end
    end

    // R4: tick flag sticky, R7 zero data and independent clears
    force_mismatch_and_clear();
    tick_en = 8'h80;
    cnt_inc = 8'h80;
    step();
    cnt_inc = '0;
    alarm_val = cnt_val;
    step();
    repeat (3) step();
    chk(tick_flag == 1'b1, "R4 tick sticky", int'(tick_flag), 1);
    chk(alarm_flag == 1'b1, "R6 alarm edge set", int'(alarm_flag), 1);
    loc_wr = 1'b1; loc_wdata = 2'b00;
    step();
    chk({tick_flag, alarm_flag} == 2'b11, "R7 zero write no effect",
        int'({tick_flag, alarm_flag}), 3);
    loc_wdata = 2'b01;
    step();
    loc_wr = 1'b0; loc_wdata = 2'b00;
    chk({tick_flag, alarm_flag} == 2'b01, "R4 tick clear only",
        int'({tick_flag, alarm_flag}), 1);
    chk_irq();
    loc_wr = 1'b1; loc_wdata = 2'b10;
    step();
    loc_wr = 1'b0; loc_wdata = 2'b00;
    chk({tick_flag, alarm_flag, irq} == 3'b000, "R7 alarm clear",
        int'({tick_flag, alarm_flag, irq}), 0);

    // R9: set and clear collide
    force_mismatch_and_clear();
    tick_en = 8'h01;
    cnt_inc = 8'h01;
    alarm_val = cnt_val;
    loc_wr = 1'b1; loc_wdata = 2'b11;
    step();
    cnt_inc = '0;
    loc_wr = 1'b0; loc_wdata = 2'b00;
    chk({tick_flag, alarm_flag} == 2'b11, "R9 set wins",
        int'({tick_flag, alarm_flag}), 3);
    chk_irq();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule